// File: doc/BRIEF.md
# MMU Fault Status Capture

This block sits beside a page table walker and records the outcome of each failed translation. The walker presents one result per request: the virtual address, the access index (encoding read/write, fetch and privilege), and a fault code made of a walk level and a fault type. A zero type means the walk succeeded. On a real fault the block merges the access index and fault code into a status register and latches the page-aligned virtual address into an address register. If software has not yet read the previous status, the new record is marked as an overflow.

The block also decides what the faulting access leads to. With the no-fault control bit set, or with traps disabled, no exception is raised. Instead a forced full-permission 4 KB mapping is signalled. Otherwise a one-cycle exception pulse is raised, tagged as an instruction fault or a data fault. For user accesses in no-fault mode, permission errors are ignored and the access proceeds as a normal mapping. Software reads both registers through a small read port. Reading the status register also clears it.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset the status and address registers read zero and mapOk, mapForce, trapPulse and trapFetch are low.
- R2: A captured fault sets status bit 1 (address valid), writes the fault type into bits 4:2, the access index into bits 7:5 and the walk level into bits 9:8. All other bits are zero unless R3 applies.
- R3: If the status register is non-zero when a fault is captured and is not being read in that cycle, the new status is overflow bit 0 set, ORed with the fields of R2 from the new fault only. Earlier fields are discarded.
- R4: Every captured fault loads the address register with the request address with its low PAGE_BITS (12) bits cleared. Requests that are not captured leave it unchanged.
- R5: rdData shows the status (zero-extended) when rdSel is 0 and the address register when rdSel is 1, combinationally. A read with rdEn high and rdSel 0 clears the status at the next edge. A read with rdSel 1 changes nothing.
- R6: When a status read and a captured fault fall in the same cycle, rdData returns the old status. The new status holds the fault fields of R2 with overflow bit 0 clear.
- R7: A captured fault with noFaultEn high or trapsEn low gives a one-cycle mapForce pulse in the cycle after the request, and no trapPulse.
- R8: A captured fault with noFaultEn low and trapsEn high gives a one-cycle trapPulse in the cycle after the request. trapFetch then equals reqFetch (1 = instruction fault, 0 = data fault). trapFetch is low whenever trapPulse is low.
- R9: A fault of type 2 (protection) or type 3 (privilege) on a user access (reqUser high) while noFaultEn is high is ignored. Neither register changes, and mapOk pulses in the next cycle. Fault types 1 and 4, and supervisor accesses, are still captured.
- R10: A request with type 0 is not captured and gives a mapOk pulse in the next cycle.
- R11: At most one of mapOk, mapForce and trapPulse is high in any cycle. Each follows exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noFaultEn | input | 1 | No-fault mode control bit |
| trapsEn | input | 1 | Traps enabled |
| reqValid | input | 1 | Walk result valid this cycle |
| reqVa | input | VA_W | Virtual address of the access |
| reqLevel | input | 2 | Walk level at which the fault was found |
| reqType | input | 3 | Fault type, 0 = no fault |
| reqAccIdx | input | 3 | Access index of the request |
| reqFetch | input | 1 | Request is an instruction fetch |
| reqUser | input | 1 | Request is a user-mode access |
| rdEn | input | 1 | Register read strobe |
| rdSel | input | 1 | Read select: 0 status, 1 address |
| rdData | output | VA_W | Read data |
| mapOk | output | 1 | Normal mapping may proceed |
| mapForce | output | 1 | Forced read/write/execute 4 KB mapping |
| trapPulse | output | 1 | Exception request pulse |
| trapFetch | output | 1 | Exception is an instruction fault |

## Verification
The hardest case to reach is a status read and a new fault landing in the same cycle while the register already holds an unread record. Only there does the read-clear priority decide whether the overflow bit appears. The stimulus first leaves a record unread, then issues a read strobe together with the next fault. It also repeats the pattern with an empty register. A second awkward corner is the user/no-fault filter. The same permission fault types are sent in user and supervisor mode, with and without no-fault, to show that only the user case is dropped. A long randomised run then mixes all of these against the cycle model.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  // status register layout
  localparam int STAT_W   = 10;
  localparam int OVF_BIT  = 0;
  localparam int FAV_BIT  = 1;
  localparam int TYPE_LSB = 2;
  localparam int TYPE_W   = 3;
  localparam int AIDX_LSB = 5;
  localparam int AIDX_W   = 3;
  localparam int LVL_LSB  = 8;
  localparam int LVL_W    = 2;

  // fault types that count as permission errors
  localparam logic [TYPE_W-1:0] FT_NONE = 3'd0;
  localparam logic [TYPE_W-1:0] FT_PROT = 3'd2;
  localparam logic [TYPE_W-1:0] FT_PRIV = 3'd3;

  typedef struct packed {
    logic capture;    // load a new fault record
    logic clearStat;  // status read clears the register
    logic keepOvf;    // a previous record is being overwritten
  } mfcStrobe_t;

  function automatic logic isPermFault(input logic [TYPE_W-1:0] t);
    return (t == FT_PROT) || (t == FT_PRIV);
  endfunction
endpackage

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
  import mfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              noFaultEn,
  input  logic              trapsEn,
  input  logic              reqValid,
  input  logic [TYPE_W-1:0] reqType,
  input  logic              reqFetch,
  input  logic              reqUser,
  input  logic              rdEn,
  input  logic              rdSel,
  input  logic              statNonZero,
  output mfcStrobe_t        strobe,
  output logic              mapOk,
  output logic              mapForce,
  output logic              trapPulse,
  output logic              trapFetch
);
  logic hasFault;
  logic ignoreFault;
  logic capture;
  logic clearStat;
  logic suppress;

  always_comb begin
    hasFault    = reqValid && (reqType != FT_NONE);
    ignoreFault = hasFault && reqUser && noFaultEn && isPermFault(reqType);
    capture     = hasFault && !ignoreFault;
    clearStat   = rdEn && !rdSel;
    suppress    = noFaultEn || !trapsEn;

    strobe.capture   = capture;
    strobe.clearStat = clearStat;
    strobe.keepOvf   = statNonZero && !clearStat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mapOk     <= 1'b0;
      mapForce  <= 1'b0;
      trapPulse <= 1'b0;
      trapFetch <= 1'b0;
    end else begin
      mapOk     <= reqValid && !capture;
      mapForce  <= capture && suppress;
      trapPulse <= capture && !suppress;
      trapFetch <= capture && !suppress && reqFetch;
    end
  end
endmodule

// File: rtl/mfc_datapath.sv
module mfc_datapath
  import mfc_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mfcStrobe_t        strobe,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [LVL_W-1:0]  reqLevel,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [AIDX_W-1:0] reqAccIdx,
  input  logic              rdSel,
  output logic [STAT_W-1:0] statusQ,
  output logic [VA_W-1:0]   addrQ,
  output logic              statNonZero,
  output logic [VA_W-1:0]   rdData
);
  localparam int PAD_W = VA_W - STAT_W;
  localparam logic [VA_W-1:0] PAGE_MASK =
    {{(VA_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  logic [STAT_W-1:0] freshStat;
  logic [STAT_W-1:0] statNext;
  logic [VA_W-1:0]   statWide;

  always_comb begin
    freshStat = '0;
    freshStat[FAV_BIT] = 1'b1;
    freshStat[TYPE_LSB +: TYPE_W] = reqType;
    freshStat[AIDX_LSB +: AIDX_W] = reqAccIdx;
    freshStat[LVL_LSB +: LVL_W]   = reqLevel;
    freshStat[OVF_BIT] = strobe.keepOvf;

    if (strobe.capture)        statNext = freshStat;
    else if (strobe.clearStat) statNext = '0;
    else                       statNext = statusQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ <= '0;
      addrQ   <= '0;
    end else begin
      statusQ <= statNext;
      if (strobe.capture) addrQ <= reqVa & PAGE_MASK;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign statWide = {{PAD_W{1'b0}}, statusQ};
    end else begin : g_nopad
      assign statWide = statusQ[VA_W-1:0];
    end
  endgenerate

  assign statNonZero = |statusQ;
  assign rdData      = rdSel ? addrQ : statWide;
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mfc_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            noFaultEn,
  input  logic            trapsEn,
  input  logic            reqValid,
  input  logic [VA_W-1:0] reqVa,
  input  logic [1:0]      reqLevel,
  input  logic [2:0]      reqType,
  input  logic [2:0]      reqAccIdx,
  input  logic            reqFetch,
  input  logic            reqUser,
  input  logic            rdEn,
  input  logic            rdSel,
  output logic [VA_W-1:0] rdData,
  output logic            mapOk,
  output logic            mapForce,
  output logic            trapPulse,
  output logic            trapFetch
);
  mfcStrobe_t        strobe;
  logic              statNonZero;
  logic [STAT_W-1:0] statusQ;
  logic [VA_W-1:0]   addrQ;

  mfc_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .noFaultEn(noFaultEn), .trapsEn(trapsEn),
    .reqValid(reqValid), .reqType(reqType), .reqFetch(reqFetch),
    .reqUser(reqUser), .rdEn(rdEn), .rdSel(rdSel),
    .statNonZero(statNonZero), .strobe(strobe), .mapOk(mapOk),
    .mapForce(mapForce), .trapPulse(trapPulse), .trapFetch(trapFetch)
  );

  mfc_datapath #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqVa(reqVa),
    .reqLevel(reqLevel), .reqType(reqType), .reqAccIdx(reqAccIdx),
    .rdSel(rdSel), .statusQ(statusQ), .addrQ(addrQ),
    .statNonZero(statNonZero), .rdData(rdData)
  );
endmodule

// File: rtl/mmu_fault_capture_chk.sv
module mmu_fault_capture_chk
  import mfc_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              noFaultEn,
  input logic              trapsEn,
  input logic              reqValid,
  input logic [2:0]        reqType,
  input logic              reqFetch,
  input logic              reqUser,
  input logic              rdEn,
  input logic              rdSel,
  input logic              mapOk,
  input logic              mapForce,
  input logic              trapPulse,
  input logic              trapFetch,
  input logic [STAT_W-1:0] statusQ,
  input logic [VA_W-1:0]   addrQ
);
  logic permDrop;
  logic capCond;
  logic statRead;
  assign permDrop = reqValid && reqUser && noFaultEn && isPermFault(reqType);
  assign capCond  = reqValid && (reqType != FT_NONE) && !permDrop;
  assign statRead = rdEn && !rdSel;

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mapOk, mapForce, trapPulse}));

  assert_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capCond |=> statusQ[FAV_BIT] && (statusQ[TYPE_LSB +: TYPE_W] == $past(reqType)));

  assert_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (capCond && (statusQ != '0) && !statRead) |=> statusQ[OVF_BIT]);

  assert_page_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addrQ[PAGE_BITS-1:0] == '0);

  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (statRead && !reqValid) |=> statusQ == '0);

  assert_read_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (statRead && capCond) |=> !statusQ[OVF_BIT] && statusQ[FAV_BIT]);

  assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capCond && (noFaultEn || !trapsEn)) |=> mapForce && !trapPulse);

  assert_trap_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (capCond && !noFaultEn && trapsEn) |=> trapPulse && (trapFetch == $past(reqFetch)));

  assert_fetch_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !trapPulse |-> !trapFetch);

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (permDrop && !statRead) |=> mapOk && $stable(statusQ) && $stable(addrQ));

  assert_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && (reqType == FT_NONE)) |=> mapOk);
endmodule

bind mmu_fault_capture mmu_fault_capture_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .noFaultEn(noFaultEn), .trapsEn(trapsEn),
  .reqValid(reqValid), .reqType(reqType), .reqFetch(reqFetch),
  .reqUser(reqUser), .rdEn(rdEn), .rdSel(rdSel), .mapOk(mapOk),
  .mapForce(mapForce), .trapPulse(trapPulse), .trapFetch(trapFetch),
  .statusQ(statusQ), .addrQ(addrQ)
);

// File: tb/mmu_fault_capture_tb_top.sv
module mmu_fault_capture_tb_top;
  localparam int VA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic noFaultEn = 0, trapsEn = 0, reqValid = 0, reqFetch = 0, reqUser = 0;
  logic rdEn = 0, rdSel = 0;
  logic [VA_W-1:0] reqVa = '0;
  logic [1:0] reqLevel = '0;
  logic [2:0] reqType = '0, reqAccIdx = '0;
  logic [VA_W-1:0] rdData;
  logic mapOk, mapForce, trapPulse, trapFetch;

  int total = 0;
  int bad = 0;

  // reference state
  logic [VA_W-1:0] mStat = '0;
  logic [VA_W-1:0] mAddr = '0;
  bit mOk = 0, mForce = 0, mTrap = 0, mFetch = 0;

  always #5 clk = ~clk;

  mmu_fault_capture #(.VA_W(VA_W), .PAGE_BITS(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .noFaultEn(noFaultEn), .trapsEn(trapsEn),
    .reqValid(reqValid), .reqVa(reqVa), .reqLevel(reqLevel),
    .reqType(reqType), .reqAccIdx(reqAccIdx), .reqFetch(reqFetch),
    .reqUser(reqUser), .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData),
    .mapOk(mapOk), .mapForce(mapForce), .trapPulse(trapPulse),
    .trapFetch(trapFetch)
  );

  task automatic chk(input string tag, input string what,
                     input logic [VA_W-1:0] act, input logic [VA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "rdData", rdData, rdSel ? mAddr : mStat);
    chk(tag, "mapOk", {31'd0, mapOk}, {31'd0, mOk});
    chk(tag, "mapForce", {31'd0, mapForce}, {31'd0, mForce});
    chk(tag, "trapPulse", {31'd0, trapPulse}, {31'd0, mTrap});
    chk(tag, "trapFetch", {31'd0, trapFetch}, {31'd0, mFetch});
  endtask

  task automatic cyc(input string tag, input bit v, input logic [31:0] va,
                     input logic [1:0] lv, input logic [2:0] ty,
                     input logic [2:0] ai, input bit f, input bit u,
                     input bit nf, input bit te, input bit re, input bit rs);
    bit perm, ign, cap, clr;
    logic [VA_W-1:0] ns;
    @(negedge clk);
    checkAll(tag);
    reqValid = v; reqVa = va; reqLevel = lv; reqType = ty; reqAccIdx = ai;
    reqFetch = f; reqUser = u; noFaultEn = nf; trapsEn = te; rdEn = re; rdSel = rs;
    perm = (ty == 3'd2) || (ty == 3'd3);
    ign  = v && (ty != 0) && u && nf && perm;
    cap  = v && (ty != 0) && !ign;
    clr  = re && !rs;
    mOk    = v && !cap;
    mForce = cap && (nf || !te);
    mTrap  = cap && !nf && te;
    mFetch = mTrap && f;
    if (cap) begin
      ns = ((mStat != 0) && !clr) ? 32'd1 : 32'd0;
      ns = ns | 32'd2 | (32'(ty) << 2) | (32'(ai) << 5) | (32'(lv) << 8);
      mStat = ns;
      mAddr = va & 32'hFFFF_F000;
    end else if (clr) begin
      mStat = '0;
    end
  endtask

  task automatic idle(input string tag, input bit re, input bit rs);
    cyc(tag, 0, 32'h0, 2'd0, 3'd0, 3'd0, 0, 0, 0, 1, re, rs);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset status", 0, 0);
    idle("R1 reset address", 0, 1);
    // R10 clean walk
    cyc("R10 clean", 1, 32'h1234_5678, 2'd3, 3'd0, 3'd4, 0, 1, 0, 1, 0, 0);
    idle("R10 clean after", 0, 0);
    // R2/R8 fetch fault with trap
    cyc("R2 R8 fetch fault", 1, 32'hDEAD_BEEF, 2'd2, 3'd1, 3'd5, 1, 0, 0, 1, 0, 0);
    idle("R8 trap pulse", 0, 0);
    idle("R4 address", 0, 1);
    // R3 overflow, data fault
    cyc("R3 R8 second fault", 1, 32'h0000_1FFF, 2'd1, 3'd4, 3'd2, 0, 1, 0, 1, 0, 0);
    idle("R3 overflow status", 0, 0);
    // R5 read clear and address read non-destructive
    idle("R5 read addr", 1, 1);
    idle("R5 addr kept", 1, 0);
    idle("R5 cleared", 0, 0);
    // R6 read and fault same cycle, empty register
    cyc("R6 empty", 1, 32'h8000_0ABC, 2'd0, 3'd4, 3'd1, 0, 0, 0, 1, 1, 0);
    idle("R6 no overflow", 0, 0);
    // R6 with unread record present
    cyc("R6 full", 1, 32'h4000_0001, 2'd3, 3'd1, 3'd7, 1, 0, 0, 1, 1, 0);
    idle("R6 fresh only", 0, 0);
    idle("R6 clear", 1, 0);
    // R7 no-fault and traps disabled
    cyc("R7 nofault", 1, 32'h0F0F_0F0F, 2'd1, 3'd1, 3'd3, 0, 0, 1, 1, 0, 0);
    cyc("R7 traps off", 1, 32'hF0F0_F0F0, 2'd2, 3'd4, 3'd6, 1, 1, 0, 0, 0, 0);
    idle("R7 after", 0, 0);
    idle("R7 clear", 1, 0);
    // R9 permission filter
    cyc("R9 user prot", 1, 32'h1111_1111, 2'd3, 3'd2, 3'd0, 0, 1, 1, 1, 0, 0);
    cyc("R9 user priv", 1, 32'h2222_2222, 2'd3, 3'd3, 3'd2, 0, 1, 1, 1, 0, 1);
    cyc("R9 super prot", 1, 32'h3333_3333, 2'd2, 3'd2, 3'd1, 0, 0, 1, 1, 0, 1);
    cyc("R9 user xlate", 1, 32'h4444_4444, 2'd1, 3'd4, 3'd0, 0, 1, 1, 1, 0, 0);
    cyc("R9 user prot nofault off", 1, 32'h5555_5555, 2'd3, 3'd2, 3'd0, 0, 1, 0, 1, 0, 0);
    idle("R9 R11 after", 0, 1);
    idle("R9 after status", 0, 0);
    // randomised mix
    for (int i = 0; i < 400; i++) begin
      cyc("R11 random", $urandom_range(0, 3) != 0, $urandom, 2'($urandom),
          3'($urandom_range(0, 4)), 3'($urandom), 1'($urandom), 1'($urandom),
          $urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0,
          $urandom_range(0, 2) == 0, 1'($urandom));
    end
    idle("R11 final", 0, 0);
    @(negedge clk);
    checkAll("R11 final");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule